// File: doc/BRIEF.md
# Host Byte Mailbox for a Coprocessor Data Register

This block connects a host bus that moves one byte per access to the 16-bit data register of an attached coprocessor. The host sees two byte locations: a data port, and a status port that it can only read. The coprocessor side loads and reads the full 16-bit register, raises a handshake flag when it posts a result or wants input, and chooses whether the data port behaves as a single-byte register or as a two-byte register.

In two-byte mode, host accesses to the data port step through the low byte and then the high byte. A low-byte write from the host is held aside and reaches the register only together with its high byte. The handshake flag drops once the host has made a full-width access. The coprocessor can poll the flag to learn when the host is done. Address decode of the host memory map and any DMA engine sit outside the block and reach it only as chip-select and strobe inputs.

Top module: `mbx_host_port`

## Requirements
- R1: After reset, the status byte reads 0x00, `cp_rqm` is 0, `cp_rdata` is 0x0000, the port is in one-byte mode, and the byte pointer is at the low byte.
- R2: When `host_addr` is 1, a host read returns the status byte. Bit 7 is the handshake flag. Bit 6 is the direction (1 = the coprocessor expects the host to read). Bit 4 is the width mode (1 = two-byte). All other bits read 0. Host writes to the status location change nothing.
- R3: A `cp_wr` pulse loads `cp_wdata` into the register, sets the flag, sets the direction to 1, and returns the byte pointer to the low byte. A host data access in the same cycle is dropped.
- R4: A `cp_req` pulse without `cp_wr` sets the flag, sets the direction to 0, and leaves the register and the byte pointer unchanged.
- R5: A `cp_mode_set` pulse selects two-byte mode when `cp_mode_wide` is 1 and one-byte mode when it is 0, and returns the byte pointer to the low byte.
- R6: In one-byte mode, every host data read returns register bits 7:0, and every host data access clears the flag.
- R7: In one-byte mode, a host data write replaces register bits 7:0 and keeps bits 15:8.
- R8: In two-byte mode, host data reads return bits 7:0 and then bits 15:8, in alternation, starting from the low byte.
- R9: In two-byte mode, a low-byte host access leaves the flag unchanged, and a high-byte access clears it.
- R10: In two-byte mode, a low-byte host write does not change `cp_rdata`. The following high-byte write commits {high, low} in one step.
- R11: Strobes that arrive while `host_cs` is 0 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host chip select for this block |
| host_addr | input | 1 | 0 = data port, 1 = status port |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access; takes precedence over read |
| host_wdata | input | HOST_W | Host write byte |
| host_rdata | output | HOST_W | Host read byte |
| cp_wr | input | 1 | Coprocessor loads the data register |
| cp_wdata | input | DATA_W | Word loaded by `cp_wr` |
| cp_req | input | 1 | Coprocessor asks the host for input |
| cp_mode_set | input | 1 | Coprocessor updates the width mode |
| cp_mode_wide | input | 1 | Width mode applied by `cp_mode_set` |
| cp_rdata | output | DATA_W | Current data register |
| cp_rqm | output | 1 | Handshake flag |

## Verification
The hardest states to reach are those in which the byte pointer sits at the high byte while something else happens. Examples are a width-mode update between the two halves of a read pair, a coprocessor load that collides with a host strobe, and a low byte staged but not yet committed. A vector table first drives complete exchanges in both widths and reads the status byte between steps. Directed sequences then stop a pair halfway and apply a mode update, a same-cycle collision, or a strobe with chip select low. After each of these, the bench reads the data port, the status port and `cp_rdata` to show where the pointer and the flag ended up.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Which half of the 16-bit register the host touches next
   typedef enum logic {
      SEL_LO = 1'b0,
      SEL_HI = 1'b1
   } byte_sel_e;

   // Handshake and mode state shown on the status byte
   typedef struct packed {
      logic rqm;
      logic dir;
      logic wide;
   } mbx_flags_t;

endpackage

// File: rtl/mbx_seq.sv
// Byte sequencer: byte pointer, handshake flag, direction, width mode.
module mbx_seq
   import mbx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_acc,
   input  logic       host_is_wr,
   input  logic       cp_wr,
   input  logic       cp_req,
   input  logic       cp_mode_set,
   input  logic       cp_mode_wide,
   output byte_sel_e  sel_o,
   output mbx_flags_t flags_o,
   output logic       ev_narrow_wr,
   output logic       ev_stage,
   output logic       ev_commit
);

   byte_sel_e  sel_q;
   mbx_flags_t flg_q;
   logic       host_go;
   logic       full_acc;

   // Coprocessor updates win the cycle; the host access is dropped
   assign host_go  = host_acc && !cp_wr && !cp_mode_set;
   assign full_acc = host_go && (!flg_q.wide || (sel_q == SEL_HI));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q      <= SEL_LO;
         flg_q.rqm  <= 1'b0;
         flg_q.dir  <= 1'b0;
         flg_q.wide <= 1'b0;
      end else begin
         if (cp_wr || cp_mode_set)
            sel_q <= SEL_LO;
         else if (host_go && flg_q.wide)
            sel_q <= (sel_q == SEL_LO) ? SEL_HI : SEL_LO;

         if (cp_wr || cp_req)
            flg_q.rqm <= 1'b1;
         else if (full_acc)
            flg_q.rqm <= 1'b0;

         if (cp_wr)
            flg_q.dir <= 1'b1;
         else if (cp_req)
            flg_q.dir <= 1'b0;

         if (cp_mode_set)
            flg_q.wide <= cp_mode_wide;
      end
   end

   assign ev_narrow_wr = host_go && host_is_wr && !flg_q.wide;
   assign ev_stage     = host_go && host_is_wr &&  flg_q.wide && (sel_q == SEL_LO);
   assign ev_commit    = host_go && host_is_wr &&  flg_q.wide && (sel_q == SEL_HI);

   assign sel_o   = sel_q;
   assign flags_o = flg_q;

endmodule

// File: rtl/mbx_datapath.sv
// Data register, staging byte and host read-byte select.
module mbx_datapath
   import mbx_pkg::*;
#(
   parameter int HOST_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cp_wr,
   input  logic [DATA_W-1:0] cp_wdata,
   input  logic              ev_narrow_wr,
   input  logic              ev_stage,
   input  logic              ev_commit,
   input  logic [HOST_W-1:0] host_wdata,
   input  byte_sel_e         sel,
   input  logic              wide,
   output logic [DATA_W-1:0] data_o,
   output logic [HOST_W-1:0] rd_byte
);

   localparam int HI_LSB = HOST_W;
   localparam int HI_MSB = DATA_W - 1;

   logic [DATA_W-1:0] data_q;
   logic [HOST_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         stage_q <= '0;
      end else begin
         if (cp_wr)
            data_q <= cp_wdata;
         else if (ev_commit)
            data_q <= {host_wdata, stage_q};
         else if (ev_narrow_wr)
            data_q[HOST_W-1:0] <= host_wdata;

         if (ev_stage)
            stage_q <= host_wdata;
      end
   end

   always_comb begin
      if (wide && (sel == SEL_HI))
         rd_byte = data_q[HI_MSB:HI_LSB];
      else
         rd_byte = data_q[HOST_W-1:0];
   end

   assign data_o = data_q;

endmodule

// File: rtl/mbx_status.sv
// Formats the status byte from the flag set.
module mbx_status
   import mbx_pkg::*;
#(
   parameter int HOST_W   = 8,
   parameter int RQM_BIT  = 7,
   parameter int DIR_BIT  = 6,
   parameter int WIDE_BIT = 4
) (
   input  mbx_flags_t        flags,
   output logic [HOST_W-1:0] status
);

   always_comb begin
      status           = '0;
      status[RQM_BIT]  = flags.rqm;
      status[DIR_BIT]  = flags.dir;
      status[WIDE_BIT] = flags.wide;
   end

endmodule

// File: rtl/mbx_host_port.sv
// Top: host byte mailbox in front of a 16-bit coprocessor data register.
module mbx_host_port
   import mbx_pkg::*;
#(
   parameter int HOST_W   = 8,
   parameter int DATA_W   = 16,
   parameter int RQM_BIT  = 7,
   parameter int DIR_BIT  = 6,
   parameter int WIDE_BIT = 4,
   parameter bit REG_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs,
   input  logic              host_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   input  logic              cp_wr,
   input  logic [DATA_W-1:0] cp_wdata,
   input  logic              cp_req,
   input  logic              cp_mode_set,
   input  logic              cp_mode_wide,
   output logic [DATA_W-1:0] cp_rdata,
   output logic              cp_rqm
);

   localparam logic ADDR_DATA = 1'b0;

   // Elaboration-time parameter checks
   if (DATA_W != 2 * HOST_W) begin : g_bad_width
      $error("DATA_W must be twice HOST_W");
   end
   if (RQM_BIT >= HOST_W || DIR_BIT >= HOST_W || WIDE_BIT >= HOST_W) begin : g_bad_bitpos
      $error("status bit position outside the host byte");
   end
   if (RQM_BIT == DIR_BIT || RQM_BIT == WIDE_BIT || DIR_BIT == WIDE_BIT) begin : g_bad_overlap
      $error("status bit positions must differ");
   end

   logic              data_sel;
   logic              host_acc;
   logic              host_is_wr;
   byte_sel_e         sel_q;
   mbx_flags_t        flags;
   logic              wide_q;
   logic              ev_narrow_wr;
   logic              ev_stage;
   logic              ev_commit;
   logic [HOST_W-1:0] data_byte;
   logic [HOST_W-1:0] status_byte;
   logic [HOST_W-1:0] rd_mux;

   assign data_sel   = host_cs && (host_addr == ADDR_DATA);
   assign host_acc   = data_sel && (host_rd || host_wr);
   assign host_is_wr = host_wr;

   mbx_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_acc     (host_acc),
      .host_is_wr   (host_is_wr),
      .cp_wr        (cp_wr),
      .cp_req       (cp_req),
      .cp_mode_set  (cp_mode_set),
      .cp_mode_wide (cp_mode_wide),
      .sel_o        (sel_q),
      .flags_o      (flags),
      .ev_narrow_wr (ev_narrow_wr),
      .ev_stage     (ev_stage),
      .ev_commit    (ev_commit)
   );

   assign wide_q = flags.wide;

   mbx_datapath #(
      .HOST_W (HOST_W),
      .DATA_W (DATA_W)
   ) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .cp_wr        (cp_wr),
      .cp_wdata     (cp_wdata),
      .ev_narrow_wr (ev_narrow_wr),
      .ev_stage     (ev_stage),
      .ev_commit    (ev_commit),
      .host_wdata   (host_wdata),
      .sel          (sel_q),
      .wide         (wide_q),
      .data_o       (cp_rdata),
      .rd_byte      (data_byte)
   );

   mbx_status #(
      .HOST_W   (HOST_W),
      .RQM_BIT  (RQM_BIT),
      .DIR_BIT  (DIR_BIT),
      .WIDE_BIT (WIDE_BIT)
   ) u_stat (
      .flags  (flags),
      .status (status_byte)
   );

   assign rd_mux = (host_addr == ADDR_DATA) ? data_byte : status_byte;

   // Read-path variant: combinational byte, or a byte captured on the strobe
   if (REG_READ) begin : g_rd_reg
      logic [HOST_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            rd_q <= '0;
         else if (host_cs && host_rd && !host_wr)
            rd_q <= rd_mux;
      end
      assign host_rdata = rd_q;
   end else begin : g_rd_comb
      assign host_rdata = rd_mux;
   end

   assign cp_rqm = flags.rqm;

endmodule

// File: rtl/mbx_host_port_chk.sv
// Protocol checker, bound to the top module.
module mbx_host_port_chk #(
   parameter int HOST_W   = 8,
   parameter int DATA_W   = 16,
   parameter bit REG_READ = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_cs,
   input logic              host_addr,
   input logic              host_rd,
   input logic              host_wr,
   input logic [HOST_W-1:0] host_rdata,
   input logic              cp_wr,
   input logic [DATA_W-1:0] cp_wdata,
   input logic              cp_req,
   input logic              cp_mode_set,
   input logic [DATA_W-1:0] cp_rdata,
   input logic              cp_rqm,
   input logic              hi_sel,
   input logic              wide
);

   logic data_acc;
   logic cp_quiet;

   assign data_acc = host_cs && (host_rd || host_wr) && (host_addr == 1'b0);
   assign cp_quiet = !cp_wr && !cp_req && !cp_mode_set;

   assert_cpwr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cp_wr |=> (cp_rqm && (cp_rdata == $past(cp_wdata)) && !hi_sel));

   assert_cpreq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && !cp_wr) |=> (cp_rqm && $stable(cp_rdata)));

   assert_mode_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cp_mode_set |=> !hi_sel);

   assert_narrow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !wide && cp_quiet) |=> !cp_rqm);

   assert_low_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && wide && !hi_sel && cp_quiet) |=> $stable(cp_rqm));

   assert_high_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && wide && hi_sel && cp_quiet) |=> !cp_rqm);

   assert_stage_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && host_wr && wide && !hi_sel && cp_quiet) |=> $stable(cp_rdata));

   assert_cs_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_cs && cp_quiet) |=> ($stable(cp_rdata) && $stable(cp_rqm) && $stable(hi_sel)));

   if (!REG_READ) begin : g_stat_chk
      assert_status_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (host_cs && host_rd && host_addr) |-> ((host_rdata[5] == 1'b0) && (host_rdata[3:0] == 4'b0000)
                                                && (host_rdata[7] == cp_rqm)));
   end

endmodule

bind mbx_host_port mbx_host_port_chk #(
   .HOST_W   (HOST_W),
   .DATA_W   (DATA_W),
   .REG_READ (REG_READ)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_cs     (host_cs),
   .host_addr   (host_addr),
   .host_rd     (host_rd),
   .host_wr     (host_wr),
   .host_rdata  (host_rdata),
   .cp_wr       (cp_wr),
   .cp_wdata    (cp_wdata),
   .cp_req      (cp_req),
   .cp_mode_set (cp_mode_set),
   .cp_rdata    (cp_rdata),
   .cp_rqm      (cp_rqm),
   .hi_sel      (sel_q),
   .wide        (wide_q)
);

// File: tb/tb_mbx_host_port.sv
`timescale 1ns/1ps
module tb_mbx_host_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_cs = 1'b0;
   logic        host_addr = 1'b0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        cp_wr = 1'b0;
   logic [15:0] cp_wdata = '0;
   logic        cp_req = 1'b0;
   logic        cp_mode_set = 1'b0;
   logic        cp_mode_wide = 1'b0;
   logic [15:0] cp_rdata;
   logic        cp_rqm;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mbx_host_port dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_cs      (host_cs),
      .host_addr    (host_addr),
      .host_rd      (host_rd),
      .host_wr      (host_wr),
      .host_wdata   (host_wdata),
      .host_rdata   (host_rdata),
      .cp_wr        (cp_wr),
      .cp_wdata     (cp_wdata),
      .cp_req       (cp_req),
      .cp_mode_set  (cp_mode_set),
      .cp_mode_wide (cp_mode_wide),
      .cp_rdata     (cp_rdata),
      .cp_rqm       (cp_rqm)
   );

   // Vector ops
   localparam logic [3:0] OP_HST = 4'd0;  // read status, expect exp[7:0]
   localparam logic [3:0] OP_HRD = 4'd1;  // read data port, expect exp[7:0]
   localparam logic [3:0] OP_HWR = 4'd2;  // write data port arg[7:0]
   localparam logic [3:0] OP_CPW = 4'd3;  // coprocessor load arg
   localparam logic [3:0] OP_REQ = 4'd4;  // coprocessor input request
   localparam logic [3:0] OP_MOD = 4'd5;  // mode set, arg[0] = wide
   localparam logic [3:0] OP_CHK = 4'd6;  // expect cp_rdata == exp
   localparam logic [3:0] OP_HSW = 4'd7;  // write status port arg[7:0]

   localparam int NV = 29;
   // {op, arg, exp, requirement number}
   localparam logic [39:0] VEC [0:NV-1] = '{
      {OP_HST, 16'h0000, 16'h0000, 4'd1},   // R1 idle status
      {OP_CPW, 16'h1234, 16'h0000, 4'd3},
      {OP_HST, 16'h0000, 16'h00C0, 4'd3},   // R3 flag + dir set
      {OP_HRD, 16'h0000, 16'h0034, 4'd6},   // R6 low byte in narrow
      {OP_HST, 16'h0000, 16'h0040, 4'd6},   // R6 flag cleared
      {OP_HWR, 16'h00AB, 16'h0000, 4'd7},
      {OP_CHK, 16'h0000, 16'h12AB, 4'd7},   // R7 high kept
      {OP_MOD, 16'h0001, 16'h0000, 4'd5},
      {OP_HST, 16'h0000, 16'h0050, 4'd5},   // R5 wide bit
      {OP_CPW, 16'hBEEF, 16'h0000, 4'd3},
      {OP_HST, 16'h0000, 16'h00D0, 4'd2},   // R2 layout
      {OP_HRD, 16'h0000, 16'h00EF, 4'd8},   // R8 low first
      {OP_HST, 16'h0000, 16'h00D0, 4'd9},   // R9 flag held after low
      {OP_HRD, 16'h0000, 16'h00BE, 4'd8},   // R8 then high
      {OP_HST, 16'h0000, 16'h0050, 4'd9},   // R9 cleared after high
      {OP_REQ, 16'h0000, 16'h0000, 4'd4},
      {OP_HST, 16'h0000, 16'h0090, 4'd4},   // R4 dir = 0
      {OP_CHK, 16'h0000, 16'hBEEF, 4'd4},   // R4 data kept
      {OP_HWR, 16'h0011, 16'h0000, 4'd10},
      {OP_CHK, 16'h0000, 16'hBEEF, 4'd10},  // R10 staged only
      {OP_HST, 16'h0000, 16'h0090, 4'd9},
      {OP_HWR, 16'h0022, 16'h0000, 4'd10},
      {OP_CHK, 16'h0000, 16'h2211, 4'd10},  // R10 commit
      {OP_HST, 16'h0000, 16'h0010, 4'd9},
      {OP_HRD, 16'h0000, 16'h0011, 4'd8},
      {OP_HRD, 16'h0000, 16'h0022, 4'd8},
      {OP_MOD, 16'h0000, 16'h0000, 4'd5},
      {OP_HSW, 16'h00FF, 16'h0000, 4'd2},
      {OP_HST, 16'h0000, 16'h0000, 4'd2}    // R2 status write ignored
   };

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, got, exp);
      end
   endtask

   task automatic host_cycle(input logic cs, input logic addr, input logic rd, input logic wr,
                             input logic [7:0] wd, output logic [7:0] rv);
      @(negedge clk);
      host_cs = cs; host_addr = addr; host_rd = rd; host_wr = wr; host_wdata = wd;
      #1 rv = host_rdata;
      @(negedge clk);
      host_cs = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
   endtask

   task automatic cp_cycle(input logic wr, input logic [15:0] wd, input logic req,
                           input logic ms, input logic mw);
      @(negedge clk);
      cp_wr = wr; cp_wdata = wd; cp_req = req; cp_mode_set = ms; cp_mode_wide = mw;
      @(negedge clk);
      cp_wr = 1'b0; cp_req = 1'b0; cp_mode_set = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state at the ports
      check("R1 rqm", {15'd0, cp_rqm}, 16'h0000);
      check("R1 rdata", cp_rdata, 16'h0000);

      // Vector walk
      for (int i = 0; i < NV; i++) begin
         logic [3:0]  op;
         logic [15:0] arg;
         logic [15:0] exp;
         string       tag;
         op  = VEC[i][39:36];
         arg = VEC[i][35:20];
         exp = VEC[i][19:4];
         tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
         case (op)
            OP_HST: begin host_cycle(1, 1, 1, 0, 8'h00, rv); check(tag, {8'h00, rv}, exp); end
            OP_HRD: begin host_cycle(1, 0, 1, 0, 8'h00, rv); check(tag, {8'h00, rv}, exp); end
            OP_HWR: host_cycle(1, 0, 0, 1, arg[7:0], rv);
            OP_HSW: host_cycle(1, 1, 0, 1, arg[7:0], rv);
            OP_CPW: cp_cycle(1, arg, 0, 0, 0);
            OP_REQ: cp_cycle(0, 16'h0000, 1, 0, 0);
            OP_MOD: cp_cycle(0, 16'h0000, 0, 1, arg[0]);
            OP_CHK: check(tag, cp_rdata, exp);
            default: ;
         endcase
      end

      // R5 mode update halfway through a read pair returns pointer to low
      cp_cycle(0, 16'h0000, 0, 1, 1);
      cp_cycle(1, 16'hA5C3, 0, 0, 0);
      host_cycle(1, 0, 1, 0, 8'h00, rv); check("R8 pair low", {8'h00, rv}, 16'h00C3);
      cp_cycle(0, 16'h0000, 0, 1, 1);
      host_cycle(1, 0, 1, 0, 8'h00, rv); check("R5 pointer reset", {8'h00, rv}, 16'h00C3);
      host_cycle(1, 0, 1, 0, 8'h00, rv); check("R8 high after reset", {8'h00, rv}, 16'h00A5);
      host_cycle(1, 1, 1, 0, 8'h00, rv); check("R9 status after pair", {8'h00, rv}, 16'h0050);

      // R11 strobes without chip select
      host_cycle(0, 0, 0, 1, 8'h77, rv);
      check("R11 write ignored", cp_rdata, 16'hA5C3);
      cp_cycle(0, 16'h0000, 1, 0, 0);
      host_cycle(0, 0, 1, 0, 8'h00, rv);
      host_cycle(0, 0, 1, 0, 8'h00, rv);
      host_cycle(1, 1, 1, 0, 8'h00, rv); check("R11 flag kept", {8'h00, rv}, 16'h0090);
      host_cycle(1, 0, 1, 0, 8'h00, rv); check("R11 pointer kept", {8'h00, rv}, 16'h00C3);

      // R3 coprocessor load collides with a high-byte host write
      @(negedge clk);
      cp_wr = 1'b1; cp_wdata = 16'h6789;
      host_cs = 1'b1; host_addr = 1'b0; host_wr = 1'b1; host_wdata = 8'h00;
      @(negedge clk);
      cp_wr = 1'b0; host_cs = 1'b0; host_wr = 1'b0;
      check("R3 collision data", cp_rdata, 16'h6789);
      check("R3 collision rqm", {15'd0, cp_rqm}, 16'h0001);
      host_cycle(1, 1, 1, 0, 8'h00, rv); check("R3 collision status", {8'h00, rv}, 16'h00D0);
      host_cycle(1, 0, 1, 0, 8'h00, rv); check("R3 pointer low", {8'h00, rv}, 16'h0089);

      // R1 reset again from a busy state
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      host_cycle(1, 1, 1, 0, 8'h00, rv); check("R1 status after reset", {8'h00, rv}, 16'h0000);
      check("R1 data after reset", cp_rdata, 16'h0000);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule